// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Unit

This block gathers the transmit and receive condition flags of a small Ethernet controller and turns them into interrupt requests. The MAC side raises one-cycle pulses for transmit faults (underflow, collision, sixteenth collision, parity error) and for receive outcomes (good frame, reset frame, runt, misalignment, CRC error, FIFO overflow). Each pulse sets a sticky bit. Four further transmit bits are level signals from the MAC, shown as they are. These are frame sent, carrier present, frame looped back and medium shorted.

Software uses a byte-wide port with an address, a write strobe and write data. Read data is combinational. For each direction, one address returns the status on a read and clears the sticky bits written as ones on a write. Two mask registers choose which bits may raise an interrupt. Two active-low summary flags show whether an enabled condition is pending in each direction. A single active-high line combines them for the interrupt controller.

Top module: `eth_irq_status`

## Requirements
- R1: After reset, all sticky bits and both masks are zero, both summary flags are 1 and `irq` is 0.
- R2: At address 0, bits 3..0 (underflow, collision, 16th collision, parity error) set one clock edge after a pulse on `tx_evt[3:0]`. They stay set until a write to address 0 with a 1 in that bit position.
- R3: At address 0, bits 7..4 (sent, carrier, looped back, shorted) follow the level inputs `tx_live[3:0]` with no delay. Writes do not affect them.
- R4: At address 2, bit 7 (good frame) and bits 4..0 (reset frame, runt, alignment, CRC, overflow) are sticky. They are set by `rx_evt[5]` and `rx_evt[4:0]` and cleared by writing ones to address 2. Bits 6 and 5 always read 0.
- R5: A write of 0 to a status bit leaves that bit unchanged.
- R6: When an event pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R7: Address 1 is the transmit mask and address 3 is the receive mask. Both are read/write. Transmit mask bit 0 (parity error) always reads 0. Receive mask bits 6 and 5 always read 0.
- R8: `tx_int_n` is 0 exactly when some bit at address 0 is 1 and its transmit mask bit is 1. Because of R7, a parity error never drives it low.
- R9: `rx_int_n` is 0 exactly when some bit at address 2 is 1 and its receive mask bit is 1.
- R10: `irq` is 1 exactly when `tx_int_n` or `rx_int_n` is 0.
- R11: Address 4 reads `{6'b0, rx_int_n, tx_int_n}`. Addresses 5 to 7 read 0, and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tx_evt | input | 4 | Transmit fault pulses: underflow, collision, 16th collision, parity |
| tx_live | input | 4 | Transmit level status: sent, carrier, looped back, shorted |
| rx_evt | input | 6 | Receive pulses: good, reset frame, runt, alignment, CRC, overflow |
| tx_int_n | output | 1 | Transmit summary, low when an enabled transmit bit is pending |
| rx_int_n | output | 1 | Receive summary, low when an enabled receive bit is pending |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest case to reach from the ports is a race between an event pulse and a software clear on the same bit in the same clock cycle. The stimulus first sets two sticky bits. It then, in a single cycle, writes ones to clear both while re-raising the pulse of only one of them. The expected result is that the re-raised bit survives and the other bit is cleared. The same race is run on the receive side. A second hard case is the parity error bit: it is set and its mask is written to 1, and the transmit summary must still stay high.

// File: rtl/eth_irq_status.sv
module eth_irq_status #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [3:0]    tx_evt,
  input  logic [3:0]    tx_live,
  input  logic [5:0]    rx_evt,
  output logic          tx_int_n,
  output logic          rx_int_n,
  output logic          irq
);
  localparam logic [AW-1:0] A_TXS = AW'(0);
  localparam logic [AW-1:0] A_TXM = AW'(1);
  localparam logic [AW-1:0] A_RXS = AW'(2);
  localparam logic [AW-1:0] A_RXM = AW'(3);
  localparam logic [AW-1:0] A_SUM = AW'(4);
  localparam logic [7:0] TXM_KEEP = 8'hFE;
  localparam logic [7:0] RXM_KEEP = 8'h9F;

  logic [3:0] tx_st;
  logic [5:0] rx_st;
  logic [7:0] tx_msk, rx_msk;
  logic [7:0] tx_view, rx_view;
  logic [3:0] tx_clr;
  logic [5:0] rx_clr;

  assign tx_clr = (bus_wr && bus_addr == A_TXS) ? bus_wdata[3:0] : 4'h0;
  assign rx_clr = (bus_wr && bus_addr == A_RXS) ? {bus_wdata[7], bus_wdata[4:0]} : 6'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st  <= '0;
      rx_st  <= '0;
      tx_msk <= '0;
      rx_msk <= '0;
    end else begin
      tx_st <= (tx_st & ~tx_clr) | tx_evt;
      rx_st <= (rx_st & ~rx_clr) | rx_evt;
      if (bus_wr && bus_addr == A_TXM) tx_msk <= bus_wdata & TXM_KEEP;
      if (bus_wr && bus_addr == A_RXM) rx_msk <= bus_wdata & RXM_KEEP;
    end
  end

  assign tx_view  = {tx_live, tx_st};
  assign rx_view  = {rx_st[5], 2'b00, rx_st[4:0]};
  assign tx_int_n = ~|(tx_view & tx_msk);
  assign rx_int_n = ~|(rx_view & rx_msk);
  assign irq      = ~(tx_int_n & rx_int_n);

  always_comb begin
    case (bus_addr)
      A_TXS:   bus_rdata = tx_view;
      A_TXM:   bus_rdata = tx_msk;
      A_RXS:   bus_rdata = rx_view;
      A_RXM:   bus_rdata = rx_msk;
      A_SUM:   bus_rdata = {6'b0, rx_int_n, tx_int_n};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module eth_irq_status_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [7:0]    bus_rdata,
  input logic [3:0]    tx_evt,
  input logic [3:0]    tx_st,
  input logic [7:0]    tx_msk,
  input logic [7:0]    rx_msk,
  input logic          tx_int_n,
  input logic          rx_int_n,
  input logic          irq
);
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == AW'(0)) && tx_evt == 4'h0) |=> $stable(tx_st));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt != 4'h0) |=> ((tx_st & $past(tx_evt)) == $past(tx_evt)));

  assert_rx_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2)) |-> (bus_rdata[6:5] == 2'b00));

  assert_parity_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_msk[0] == 1'b0) && (rx_msk[6:5] == 2'b00));

  assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_msk == 8'h00) |-> tx_int_n);

  assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_msk == 8'h00) |-> rx_int_n);

  assert_irq_join_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (!tx_int_n || !rx_int_n));
endmodule

bind eth_irq_status eth_irq_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .tx_evt(tx_evt), .tx_st(tx_st),
  .tx_msk(tx_msk), .rx_msk(rx_msk), .tx_int_n(tx_int_n),
  .rx_int_n(rx_int_n), .irq(irq)
);

// File: tb/sim_eth_irq_status.sv
`timescale 1ns/1ps
module sim_eth_irq_status;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [3:0]    tx_evt = '0;
  logic [3:0]    tx_live = '0;
  logic [5:0]    rx_evt = '0;
  logic          tx_int_n, rx_int_n, irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    bit       pins;
    logic [7:0] exp;
    string    req;
  } item_t;

  item_t q[$];
  event done_ev;

  always #2 clk = ~clk;

  eth_irq_status #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .tx_live(tx_live), .rx_evt(rx_evt), .tx_int_n(tx_int_n),
    .rx_int_n(rx_int_n), .irq(irq)
  );

  initial begin
    forever begin
      item_t it;
      logic [7:0] got;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      got = it.pins ? {5'b0, irq, rx_int_n, tx_int_n} : bus_rdata;
      compared++;
      if (got !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got %02h expected %02h", it.req, got, it.exp);
      end
      ->done_ev;
    end
  end

  task automatic expect_reg(input logic [AW-1:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.pins = 1'b0; it.exp = e; it.req = r;
    q.push_back(it);
    @(done_ev);
  endtask

  task automatic expect_pins(input logic [2:0] e, input string r);
    item_t it;
    @(negedge clk);
    it.pins = 1'b1; it.exp = {5'b0, e}; it.req = r;
    q.push_back(it);
    @(done_ev);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [3:0] te = 4'h0, input logic [5:0] re = 6'h0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tx_evt = te; rx_evt = re;
    @(negedge clk);
    bus_wr = 1'b0; tx_evt = '0; rx_evt = '0;
  endtask

  task automatic pulse(input logic [3:0] te, input logic [5:0] re);
    @(negedge clk);
    tx_evt = te; rx_evt = re;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg(0, 8'h00, "R1");
    expect_reg(1, 8'h00, "R1");
    expect_reg(2, 8'h00, "R1");
    expect_reg(3, 8'h00, "R1");
    expect_reg(4, 8'h03, "R1");
    expect_pins(3'b011, "R1");
    // R3 live bits
    tx_live = 4'b0100;
    expect_reg(0, 8'h40, "R3");
    wr(0, 8'hF0);
    expect_reg(0, 8'h40, "R3");
    tx_live = 4'b0000;
    // R2 and R5 sticky transmit faults
    pulse(4'b1010, 6'h0);
    expect_reg(0, 8'h0A, "R2");
    wr(0, 8'h00);
    expect_reg(0, 8'h0A, "R5");
    wr(0, 8'h08);
    expect_reg(0, 8'h02, "R2");
    // R7 and R8 transmit mask
    wr(1, 8'hFF);
    expect_reg(1, 8'hFE, "R7");
    expect_pins(3'b110, "R8");
    expect_reg(4, 8'h02, "R11");
    wr(0, 8'h02);
    expect_reg(0, 8'h00, "R2");
    expect_pins(3'b011, "R10");
    // R8 parity error is never enabled
    pulse(4'b0001, 6'h0);
    expect_reg(0, 8'h01, "R2");
    expect_pins(3'b011, "R8");
    wr(0, 8'h01);
    // R8 live bit with mask
    tx_live = 4'b1000;
    expect_pins(3'b110, "R8");
    tx_live = 4'b0000;
    expect_pins(3'b011, "R8");
    // R4, R7 and R9 receive side
    pulse(4'h0, 6'b111111);
    expect_reg(2, 8'h9F, "R4");
    expect_pins(3'b011, "R9");
    wr(3, 8'hFF);
    expect_reg(3, 8'h9F, "R7");
    expect_pins(3'b101, "R9");
    expect_reg(4, 8'h01, "R11");
    wr(2, 8'h7F);
    expect_reg(2, 8'h80, "R4");
    wr(2, 8'h80);
    expect_reg(2, 8'h00, "R4");
    expect_pins(3'b011, "R10");
    // R6 set beats clear
    pulse(4'b1100, 6'h0);
    expect_reg(0, 8'h0C, "R2");
    wr(0, 8'h0C, 4'b0100, 6'h0);
    expect_reg(0, 8'h04, "R6");
    pulse(4'h0, 6'b000011);
    wr(2, 8'h03, 4'h0, 6'b000001);
    expect_reg(2, 8'h01, "R6");
    // R11 unused addresses
    wr(5, 8'hFF);
    expect_reg(5, 8'h00, "R11");
    expect_reg(7, 8'h00, "R11");
    // R8 masking off removes the request
    wr(1, 8'h00);
    wr(3, 8'h00);
    expect_pins(3'b011, "R8");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule